// File: doc/BRIEF.md
# Comparator Edge-Flag Control Register

This block is the digital side of an analog voltage comparator. The comparator's raw decision arrives as a 1-bit input that can change at any time with respect to the system clock. The block brings that decision into the clock domain through a chain of flip-flops. It watches the synchronized value for transitions and keeps a sticky flag for each direction. It asserts an interrupt level while a flag whose enable is set stays set.

Two 8-bit registers sit on a simple single-cycle register bus. The control register holds the on/off switch, the live output status bit, both edge flags and two 2-bit hysteresis fields. The auxiliary register holds the two interrupt enables and a 2-bit response-mode field. The hysteresis and mode fields only drive output ports, which go to the analog macro.

The comparator result also goes toward the pin-routing network in two forms. One is synchronized to the clock. The other is a plain gate on the raw input, so it needs no clock. Both are forced low while the block is off.

Top module: `cmp_edge_ctrl`

## Requirements
- R1: After reset both registers read 0x00, and `pin_sync_o`, `pin_async_o`, `irq_o`, `hyst_pos_o`, `hyst_neg_o` and `resp_mode_o` are all 0.
- R2: Control register at address 0:
  - bit 7 is the enable, bits 3:2 are the positive hysteresis and bits 1:0 are the negative hysteresis.
  - All three fields read back as written.
  - The hysteresis fields appear on `hyst_pos_o` and `hyst_neg_o` (00 off, 01 5 mV, 10 10 mV, 11 20 mV).
- R3: Control bit 6 is read-only.
  - It returns the synchronized comparator output (1 when the positive input is above the negative input) while enabled, and 0 while disabled.
  - A write to bit 6 has no effect.
- R4: Edge flags:
  - A rising transition of the synchronized output sets control bit 5, and a falling transition sets control bit 4.
  - A flag is visible on the register port SYNC_STAGES+1 clock edges after the raw input changes.
- R5: An edge flag stays set until a bus write to the control register carries 0 in that bit position.
- R6: If a write of 0 to a flag lands in the same cycle as a new edge of that type, the flag ends up set.
- R7: No edge flag is set by the comparator while the block is disabled, or in the first cycle after it becomes enabled.
- R8: `pin_sync_o` follows the raw input through SYNC_STAGES flip-flops (2 by default) and is 0 while disabled.
- R9: `pin_async_o` equals the raw input ANDed with the enable, through no clocked path from the raw input.
- R10: Auxiliary register and unused addresses:
  - The auxiliary register at address 1 has bit 0 = rising-edge interrupt enable, bit 1 = falling-edge interrupt enable and bits 3:2 = response mode, driven on `resp_mode_o`.
  - Bits 7:4 of the auxiliary register read 0.
  - Any other address reads 0x00 and ignores writes.
- R11: `irq_o` is the level (rising flag AND rising enable) OR (falling flag AND falling enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Raw comparator decision, asynchronous |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, combinational |
| pin_sync_o | output | 1 | Synchronized comparator output toward pins |
| pin_async_o | output | 1 | Unclocked comparator output toward pins |
| irq_o | output | 1 | Interrupt level |
| hyst_pos_o | output | 2 | Positive hysteresis setting |
| hyst_neg_o | output | 2 | Negative hysteresis setting |
| resp_mode_o | output | 2 | Response-mode setting |

## Verification
The bench builds the block with SYNC_STAGES=2 and ADDR_W=2. This makes the synchronizer and flag latencies short enough to sample edge by edge, and it leaves two unused addresses that can be probed. With this build the bench can sweep every hysteresis and mode code and all four interrupt-enable combinations against both edge directions. It can also place a bus write exactly in the cycle an edge lands, and an enable write in the cycle the synchronized input first rises.

// File: rtl/cmp_edge_pkg.sv
`timescale 1ns/1ps
package cmp_edge_pkg;
    localparam int REG_W = 8;

    // control register bit positions
    localparam int CTL_EN   = 7;
    localparam int CTL_STAT = 6;
    localparam int CTL_RISE = 5;
    localparam int CTL_FALL = 4;
    localparam int CTL_HYP  = 2;
    localparam int CTL_HYN  = 0;

    // auxiliary register bit positions
    localparam int AUX_RIE  = 0;
    localparam int AUX_FIE  = 1;
    localparam int AUX_MODE = 2;

    typedef struct packed {
        logic       en;
        logic [1:0] hyp;
        logic [1:0] hyn;
        logic       rie;
        logic       fie;
        logic [1:0] mode;
    } cfg_t;

    typedef struct packed {
        logic prev;
        logic arm;
        logic rflag;
        logic fflag;
    } flag_st_t;
endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_flags.sv
`timescale 1ns/1ps
module cmp_edge_flags
    import cmp_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic level_i,
    input  logic wr_i,
    input  logic wr_rise_i,
    input  logic wr_fall_i,
    output logic rise_flag_o,
    output logic fall_flag_o
);
    flag_st_t st_d, st_q;
    logic     rise_evt, fall_evt;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        st_d.arm  = en_i;
        rise_evt  = en_i && st_q.arm && level_i && !st_q.prev;
        fall_evt  = en_i && st_q.arm && !level_i && st_q.prev;
        if (wr_i) begin
            st_d.rflag = wr_rise_i;
            st_d.fflag = wr_fall_i;
        end
        // a new edge takes precedence over a software clear
        if (rise_evt) st_d.rflag = 1'b1;
        if (fall_evt) st_d.fflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_flag_o = st_q.rflag;
    assign fall_flag_o = st_q.fflag;

    p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> rise_flag_o);
    p_fall_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> fall_flag_o);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_flag_o && !wr_i) |=> rise_flag_o);
    p_no_flag_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_i) |=> !$rose(rise_flag_o) && !$rose(fall_flag_o));
    p_first_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !st_q.arm && !wr_i) |=> $stable(rise_flag_o) && $stable(fall_flag_o));
endmodule

// File: rtl/cmp_edge_ctrl.sv
`timescale 1ns/1ps
module cmp_edge_ctrl
    import cmp_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              pin_sync_o,
    output logic              pin_async_o,
    output logic              irq_o,
    output logic [1:0]        hyst_pos_o,
    output logic [1:0]        hyst_neg_o,
    output logic [1:0]        resp_mode_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] AUX_ADDR  = ADDR_W'(1);

    cfg_t cfg_d, cfg_q;
    logic sync_lvl, rise_flag, fall_flag;
    logic wr_ctrl, wr_aux, status;
    logic unused_wbits;

    assign wr_ctrl      = bus_wr_i && (bus_addr_i == CTRL_ADDR);
    assign wr_aux       = bus_wr_i && (bus_addr_i == AUX_ADDR);
    assign unused_wbits = ^{bus_wdata_i[CTL_STAT], bus_wdata_i[7:4]};

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_raw_i),
        .dout  (sync_lvl)
    );

    cmp_edge_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (cfg_q.en),
        .level_i     (sync_lvl),
        .wr_i        (wr_ctrl),
        .wr_rise_i   (bus_wdata_i[CTL_RISE]),
        .wr_fall_i   (bus_wdata_i[CTL_FALL]),
        .rise_flag_o (rise_flag),
        .fall_flag_o (fall_flag)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.en  = bus_wdata_i[CTL_EN];
            cfg_d.hyp = bus_wdata_i[CTL_HYP +: 2];
            cfg_d.hyn = bus_wdata_i[CTL_HYN +: 2];
        end
        if (wr_aux) begin
            cfg_d.rie  = bus_wdata_i[AUX_RIE];
            cfg_d.fie  = bus_wdata_i[AUX_FIE];
            cfg_d.mode = bus_wdata_i[AUX_MODE +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign status = cfg_q.en && sync_lvl;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == CTRL_ADDR) begin
            bus_rdata_o[CTL_EN]        = cfg_q.en;
            bus_rdata_o[CTL_STAT]      = status;
            bus_rdata_o[CTL_RISE]      = rise_flag;
            bus_rdata_o[CTL_FALL]      = fall_flag;
            bus_rdata_o[CTL_HYP +: 2]  = cfg_q.hyp;
            bus_rdata_o[CTL_HYN +: 2]  = cfg_q.hyn;
        end else if (bus_addr_i == AUX_ADDR) begin
            bus_rdata_o[AUX_RIE]       = cfg_q.rie;
            bus_rdata_o[AUX_FIE]       = cfg_q.fie;
            bus_rdata_o[AUX_MODE +: 2] = cfg_q.mode;
        end
    end

    assign pin_sync_o  = status;
    assign pin_async_o = cmp_raw_i && cfg_q.en;
    assign irq_o       = (rise_flag && cfg_q.rie) || (fall_flag && cfg_q.fie);
    assign hyst_pos_o  = cfg_q.hyp;
    assign hyst_neg_o  = cfg_q.hyn;
    assign resp_mode_o = cfg_q.mode;

    p_async_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> !pin_async_o);
    p_sync_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> !pin_sync_o);
    p_status_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && bus_addr_i == CTRL_ADDR) |-> !bus_rdata_o[CTL_STAT]);
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.rie && !cfg_q.fie) |-> !irq_o);
    p_hyst_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> hyst_pos_o == $past(bus_wdata_i[CTL_HYP +: 2]));
endmodule

// File: tb/cmp_edge_ctrl_tb.sv
`timescale 1ns/1ps
module cmp_edge_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       psync, pasync, irq;
    logic [1:0] hp, hn, md;
    int         checks = 0;
    int         errs = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    cmp_edge_ctrl #(.SYNC_STAGES(2), .ADDR_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pin_sync_o(psync), .pin_async_o(pasync), .irq_o(irq),
        .hyst_pos_o(hp), .hyst_neg_o(hn), .resp_mode_o(md)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd_reg(2'd0, v); chk("R1", "ctrl reset", v, 8'h00);
        rd_reg(2'd1, v); chk("R1", "aux reset", v, 8'h00);
        chk("R1", "outputs reset", {psync, pasync, irq, hp, hn, md}, 9'h0);

        // R2 hysteresis fields, disabled and enabled (raw low -> status 0)
        for (int k = 0; k < 32; k++) begin
            logic [7:0] d;
            d = {k[4], 3'b000, k[3:0]};
            wr_reg(2'd0, d);
            rd_reg(2'd0, v);
            chk("R2", "ctrl readback", v, d);
            chk("R2", "hyst ports", {hp, hn}, d[3:0]);
        end

        // R10 auxiliary register and unused addresses
        for (int k = 0; k < 16; k++) begin
            wr_reg(2'd1, 8'hF0 | 8'(k));
            rd_reg(2'd1, v);
            chk("R10", "aux readback", v, 8'(k));
            chk("R10", "mode port", md, k[3:2]);
        end
        wr_reg(2'd0, 8'h05);
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd2, v); chk("R10", "unused addr 2", v, 8'h00);
        rd_reg(2'd3, v); chk("R10", "unused addr 3", v, 8'h00);
        rd_reg(2'd0, v); chk("R10", "ctrl kept after unused write", v, 8'h05);
        rd_reg(2'd1, v); chk("R10", "aux kept after unused write", v, 8'h0F);

        // R7/R8/R9/R3 disabled: raw toggles have no effect
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h03);
        @(negedge clk); raw = 1'b1;
        #1 chk("R9", "async low while off", pasync, 1'b0);
        idle(5);
        chk("R8", "sync low while off", psync, 1'b0);
        rd_reg(2'd0, v); chk("R7", "no flags while off (rise)", v, 8'h00);
        @(negedge clk); raw = 1'b0;
        idle(5);
        rd_reg(2'd0, v); chk("R7", "no flags while off (fall)", v, 8'h00);
        chk("R11", "no irq while off", irq, 1'b0);

        // R7 enable written in the cycle the synchronized input rises
        @(negedge clk); raw = 1'b1;
        wr_reg(2'd0, 8'h80);
        idle(3);
        rd_reg(2'd0, v); chk("R7", "no flag on enabling cycle", v, 8'hC0);
        chk("R3", "status follows input", v[6], 1'b1);
        wr_reg(2'd0, 8'hC0);
        rd_reg(2'd0, v); chk("R3", "status write ignored (high)", v, 8'hC0);
        @(negedge clk); raw = 1'b0;
        idle(4);
        rd_reg(2'd0, v); chk("R4", "fall after enable", v, 8'h90);

        // R4/R8/R9/R11 sweep over interrupt enables
        for (int c = 0; c < 4; c++) begin
            logic [1:0] ce;
            ce = 2'(c);
            wr_reg(2'd1, {6'b0, ce});
            wr_reg(2'd0, 8'h80);
            // rising edge
            @(negedge clk); raw = 1'b1;
            #1 chk("R9", "async follows rise", pasync, 1'b1);
            @(negedge clk); chk("R8", "sync still low after 1 edge", psync, 1'b0);
            @(negedge clk); chk("R8", "sync high after 2 edges", psync, 1'b1);
            rd_reg(2'd0, v); chk("R4", "rise flag not yet", v[5], 1'b0);
            @(negedge clk);
            rd_reg(2'd0, v); chk("R4", "rise flag set", v, 8'hE0);
            chk("R11", "irq after rise", irq, ce[0]);
            // falling edge
            @(negedge clk); raw = 1'b0;
            #1 chk("R9", "async follows fall", pasync, 1'b0);
            @(negedge clk); chk("R8", "sync still high after 1 edge", psync, 1'b1);
            @(negedge clk); chk("R8", "sync low after 2 edges", psync, 1'b0);
            @(negedge clk);
            rd_reg(2'd0, v); chk("R4", "both flags set", v, 8'hB0);
            chk("R11", "irq both flags", irq, ce[0] | ce[1]);
            // R5 sticky
            idle(10);
            rd_reg(2'd0, v); chk("R5", "flags sticky", v, 8'hB0);
            wr_reg(2'd0, 8'h90);
            rd_reg(2'd0, v); chk("R5", "clear rise only", v, 8'h90);
            chk("R11", "irq fall only", irq, ce[1]);
            wr_reg(2'd0, 8'hC0);
            rd_reg(2'd0, v); chk("R3", "status write ignored (low)", v, 8'h80);
            chk("R11", "irq after clear", irq, 1'b0);
        end

        // R6 clear collides with new edge
        wr_reg(2'd0, 8'h80);
        @(negedge clk); raw = 1'b1;
        @(negedge clk);
        wr_reg(2'd0, 8'h80);
        rd_reg(2'd0, v); chk("R6", "rise wins over clear", v, 8'hE0);
        @(negedge clk); raw = 1'b0;
        @(negedge clk);
        wr_reg(2'd0, 8'h80);
        rd_reg(2'd0, v); chk("R6", "fall wins over clear", v, 8'h90);

        // R8/R9 disable forces outputs low
        @(negedge clk); raw = 1'b1;
        idle(4);
        chk("R8", "sync high before disable", psync, 1'b1);
        wr_reg(2'd0, 8'h00);
        #1;
        chk("R9", "async low after disable", pasync, 1'b0);
        chk("R8", "sync low after disable", psync, 1'b0);
        rd_reg(2'd0, v); chk("R3", "status low after disable", v, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule